// File: doc/BRIEF.md
# Asynchronous Serial Transceiver with Per-Direction Bit Order

This block pairs an asynchronous serial transmitter with a receiver. Each character is framed as one low start bit, eight data bits and one high stop bit. Each direction has its own select that chooses whether data travels least significant bit first or most significant bit first. A two-bit field sets how many base ticks make up one bit time: 4, 8 or 16. All timing advances only on cycles where the base tick enable is high. Baud generation upstream of that tick is outside the block, and so are parity and FIFOs.

The transmitter accepts a byte on a start strobe whenever it is idle. It holds its busy flag until the stop bit has ended. The receiver passes the line through a two-stage synchronizer and arms on a low level. It checks the start bit again at mid-bit and then samples each following bit one bit time later. A good character is delivered with a one-cycle valid strobe and stays unread until the consumer pulses `rx_take`. A bad stop bit is reported as a framing error. A good character that arrives while the previous one is still unread is reported as an overrun.

Top module: `uart_bitorder`

## Requirements
- R1: After reset `txd` is 1, `tx_busy` is 0, `rx_data` is 0 and no receive strobe (`rx_valid`, `rx_frame_err`, `rx_overrun`) is raised. `rx_valid` is never high on two consecutive cycles.
- R2: An accepted transmit frame drives `txd` low for one bit time, then sends eight data bits, then holds `txd` high for one bit time. `tx_busy` rises on the clock edge that accepts `tx_start` and falls exactly 10 bit times later. While `tx_busy` is 0, `txd` is 1.
- R3: With `tx_msb_first`=0 the first data bit on the line is `tx_data[0]`. With `tx_msb_first`=1 it is `tx_data[7]`.
- R4: With `rx_msb_first`=0 the first received data bit lands in `rx_data[0]`. With `rx_msb_first`=1 it lands in `rx_data[7]`.
- R5: `ratio_sel` sets the bit time in base ticks: 2'b00 gives 4, 2'b01 gives 8, 2'b10 gives 16, and 2'b11 also gives 16.
- R6: A `tx_start` pulse while `tx_busy` is 1 is ignored. The frame in progress is unchanged and nothing is queued.
- R7: A low level that is high again at the mid-bit check (bit time/2 ticks after it was seen) is dropped as a glitch, with no strobe.
- R8: A stop bit sampled low pulses `rx_frame_err`, gives no `rx_valid` and leaves `rx_data` unchanged. The receiver waits for the line to go high before it re-arms.
- R9: A good character that completes while earlier data is unread (delivered and not yet acknowledged by `rx_take`) pulses `rx_overrun`, raises no `rx_valid`, and keeps `rx_data`.
- R10: Each direction latches `ratio_sel` and its order select when a frame begins. Changes made during a frame apply from the next frame.
- R11: Bit timing counts only cycles with `tick` high. While `tick` is low, `txd` and `tx_busy` hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Base clock enable |
| tx_data | input | 8 | Byte to send |
| tx_start | input | 1 | Send request, taken when idle |
| rxd | input | 1 | Serial receive line |
| tx_msb_first | input | 1 | Transmit order: 1 sends MSB first |
| rx_msb_first | input | 1 | Receive order: 1 receives MSB first |
| ratio_sel | input | 2 | Base ticks per bit select |
| rx_take | input | 1 | Consumer has read `rx_data` |
| txd | output | 1 | Serial transmit line |
| tx_busy | output | 1 | Transmit frame in progress |
| rx_data | output | 8 | Last delivered byte |
| rx_valid | output | 1 | One-cycle strobe for a new byte |
| rx_frame_err | output | 1 | One-cycle strobe for a bad stop bit |
| rx_overrun | output | 1 | One-cycle strobe for a byte lost to unread data |

## Verification
On the transmit side, bit k of a frame occupies the clock edges from P+k·R to P+(k+1)·R, where P is the edge that accepts `tx_start` and R is the bit time in ticks. The bench samples each bit on the falling clock edge R/2 cycles into the bit. It checks `tx_busy` half a cycle before and half a cycle after edge P+10·R, which pins the frame length to the exact cycle. On the receive side, a strobe comes about two synchronizer cycles plus 9.5 bit times after the falling start edge. The bench therefore counts strobes on falling edges and reads the counts only after the stop bit and two further idle bit times have passed. In the gated-tick loopback test the busy window must span 80 ticks, which is 159 or 160 cycles depending on the tick phase.

// File: rtl/uart_bitorder.sv
module uart_bitorder #(
  parameter int DW = 8,
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic [DW-1:0] tx_data,
  input  logic          tx_start,
  input  logic          rxd,
  input  logic          tx_msb_first,
  input  logic          rx_msb_first,
  input  logic [1:0]    ratio_sel,
  input  logic          rx_take,
  output logic          txd,
  output logic          tx_busy,
  output logic [DW-1:0] rx_data,
  output logic          rx_valid,
  output logic          rx_frame_err,
  output logic          rx_overrun
);
  localparam int NB = DW + 2;
  localparam int BW = $clog2(NB + 1);
  localparam logic [BW-1:0] STOP_IDX = BW'(NB - 1);
  localparam logic [BW-1:0] LAST_DATA = BW'(DW);

  function automatic logic [CW-1:0] bit_last(input logic [1:0] s);
    case (s)
      2'b00:   return CW'(3);
      2'b01:   return CW'(7);
      default: return CW'(15);
    endcase
  endfunction

  function automatic logic [DW-1:0] flip(input logic [DW-1:0] d);
    for (int i = 0; i < DW; i++) flip[i] = d[DW-1-i];
  endfunction

  // transmitter
  logic [DW:0]   tx_sh;
  logic [CW-1:0] tx_cnt, tx_last;
  logic [BW-1:0] tx_idx;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_busy <= 1'b0;
      txd     <= 1'b1;
      tx_sh   <= '1;
      tx_cnt  <= '0;
      tx_last <= CW'(15);
      tx_idx  <= '0;
    end else if (!tx_busy) begin
      if (tx_start) begin
        tx_busy <= 1'b1;
        txd     <= 1'b0;
        tx_sh   <= {1'b1, tx_msb_first ? flip(tx_data) : tx_data};
        tx_cnt  <= '0;
        tx_idx  <= '0;
        tx_last <= bit_last(ratio_sel);
      end
    end else if (tick) begin
      if (tx_cnt == tx_last) begin
        tx_cnt <= '0;
        if (tx_idx == STOP_IDX) begin
          tx_busy <= 1'b0;
          txd     <= 1'b1;
        end else begin
          txd    <= tx_sh[0];
          tx_sh  <= {1'b1, tx_sh[DW:1]};
          tx_idx <= tx_idx + 1'b1;
        end
      end else begin
        tx_cnt <= tx_cnt + 1'b1;
      end
    end
  end

  // receiver
  typedef enum logic [1:0] {RX_IDLE, RX_START, RX_DATA, RX_BREAK} rx_st_t;
  rx_st_t        rx_st;
  logic          rx_m, rx_s, rx_msb, rx_full;
  logic [CW-1:0] rx_cnt, rx_last;
  logic [BW-1:0] rx_idx;
  logic [DW-1:0] rx_sh;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_m <= 1'b1;
      rx_s <= 1'b1;
    end else begin
      rx_m <= rxd;
      rx_s <= rx_m;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_st        <= RX_IDLE;
      rx_cnt       <= '0;
      rx_last      <= CW'(15);
      rx_idx       <= '0;
      rx_sh        <= '0;
      rx_msb       <= 1'b0;
      rx_full      <= 1'b0;
      rx_data      <= '0;
      rx_valid     <= 1'b0;
      rx_frame_err <= 1'b0;
      rx_overrun   <= 1'b0;
    end else begin
      rx_valid     <= 1'b0;
      rx_frame_err <= 1'b0;
      rx_overrun   <= 1'b0;
      if (rx_take) rx_full <= 1'b0;
      case (rx_st)
        RX_IDLE:
          if (tick && !rx_s) begin
            rx_st   <= RX_START;
            rx_cnt  <= '0;
            rx_last <= bit_last(ratio_sel);
            rx_msb  <= rx_msb_first;
          end
        RX_START:
          if (tick) begin
            if (rx_cnt == (rx_last >> 1)) begin
              rx_cnt <= '0;
              rx_idx <= '0;
              rx_st  <= rx_s ? RX_IDLE : RX_DATA;
            end else begin
              rx_cnt <= rx_cnt + 1'b1;
            end
          end
        RX_DATA:
          if (tick) begin
            if (rx_cnt == rx_last) begin
              rx_cnt <= '0;
              if (rx_idx == LAST_DATA) begin
                if (!rx_s) begin
                  rx_frame_err <= 1'b1;
                  rx_st        <= RX_BREAK;
                end else begin
                  rx_st <= RX_IDLE;
                  if (rx_full && !rx_take) begin
                    rx_overrun <= 1'b1;
                  end else begin
                    rx_data  <= rx_sh;
                    rx_valid <= 1'b1;
                    rx_full  <= 1'b1;
                  end
                end
              end else begin
                rx_sh  <= rx_msb ? {rx_sh[DW-2:0], rx_s} : {rx_s, rx_sh[DW-1:1]};
                rx_idx <= rx_idx + 1'b1;
              end
            end else begin
              rx_cnt <= rx_cnt + 1'b1;
            end
          end
        default:
          if (rx_s) rx_st <= RX_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/uart_bitorder_chk.sv
module uart_bitorder_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          tick,
  input logic          txd,
  input logic          tx_busy,
  input logic [DW-1:0] rx_data,
  input logic          rx_valid,
  input logic          rx_frame_err,
  input logic          rx_overrun
);
  // R2
  start_bit_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_busy) |-> !txd);

  // R2
  idle_line_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_busy |-> txd);

  // R11
  hold_without_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_busy && !tick) |=> ($stable(txd) && tx_busy));

  // R8
  single_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({rx_valid, rx_frame_err, rx_overrun}) <= 1);

  // R9
  overrun_keeps_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_overrun |-> $stable(rx_data));

  // R1
  valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);
endmodule

bind uart_bitorder uart_bitorder_chk #(.DW(DW)) u_chk (.*);

// File: tb/uart_bitorder_bench.sv
module uart_bitorder_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic tick_slow = 1'b0, tick_ph = 1'b0, tick;
  logic [7:0] tx_data = '0;
  logic tx_start = 1'b0, rx_drv = 1'b1, loop = 1'b0, rxd;
  logic tx_msb_first = 1'b0, rx_msb_first = 1'b0, rx_take = 1'b0;
  logic [1:0] ratio_sel = 2'b10;
  logic txd, tx_busy, rx_valid, rx_frame_err, rx_overrun;
  logic [7:0] rx_data;
  int n_chk = 0, n_fail = 0, n_val = 0, n_fe = 0, n_ov = 0;

  always #4 clk = ~clk;
  always @(negedge clk) tick_ph <= ~tick_ph;
  assign tick = tick_slow ? tick_ph : 1'b1;
  assign rxd = loop ? txd : rx_drv;

  uart_bitorder u_uart_bitorder (.*);

  always @(negedge clk) begin
    if (rx_valid) n_val++;
    if (rx_frame_err) n_fe++;
    if (rx_overrun) n_ov++;
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int ratio_of(input logic [1:0] s);
    return (s == 2'b00) ? 4 : (s == 2'b01) ? 8 : 16;
  endfunction

  function automatic logic [7:0] rev8(input logic [7:0] d);
    for (int i = 0; i < 8; i++) rev8[i] = d[7-i];
  endfunction

  task automatic t_reset();
    chk(txd === 1'b1, "R1 txd", 32'(txd), 1);
    chk(tx_busy === 1'b0, "R1 tx_busy", 32'(tx_busy), 0);
    chk(rx_data === 8'h00, "R1 rx_data", 32'(rx_data), 0);
    chk((n_val + n_fe + n_ov) == 0, "R1 strobes", n_val + n_fe + n_ov, 0);
  endtask

  // poke: tx_start while busy (R6); flip: change controls mid-frame (R10)
  task automatic t_tx(input logic [7:0] d, input logic msb, input logic [1:0] sel, input bit poke, input bit flip);
    int r = ratio_of(sel);
    logic [9:0] fr;
    fr[0] = 1'b0;
    fr[9] = 1'b1;
    for (int i = 0; i < 8; i++) fr[i+1] = msb ? d[7-i] : d[i];
    @(negedge clk);
    tx_data = d; tx_msb_first = msb; ratio_sel = sel; tx_start = 1'b1;
    @(negedge clk);
    tx_start = 1'b0;
    chk(tx_busy === 1'b1, "R2 busy after start", 32'(tx_busy), 1);
    if (flip) begin
      tx_msb_first = ~msb;
      ratio_sel = (sel == 2'b00) ? 2'b10 : 2'b00;
      tx_data = ~d;
    end
    repeat (r/2) @(negedge clk);
    for (int k = 0; k < 10; k++) begin
      chk(txd === fr[k], flip ? "R10 tx bit" : (k == 0 || k == 9) ? "R2 tx framing bit" : "R3 tx data bit", 32'(txd), 32'(fr[k]));
      if (poke && k == 3) begin
        tx_data = ~d; tx_start = 1'b1;
        @(negedge clk);
        tx_start = 1'b0;
        repeat (r - 1) @(negedge clk);
      end else if (k < 9) begin
        repeat (r) @(negedge clk);
      end
    end
    repeat (r/2 - 1) @(negedge clk);
    chk(tx_busy === 1'b1, "R5 busy before last edge", 32'(tx_busy), 1);
    @(negedge clk);
    chk(tx_busy === 1'b0, poke ? "R6 busy ends, nothing queued" : "R5 busy ends after 10 bit times", 32'(tx_busy), 0);
    repeat (3) @(negedge clk);
    chk(tx_busy === 1'b0 && txd === 1'b1, "R6 idle after frame", 32'({tx_busy, txd}), 1);
  endtask

  task automatic send_line(input logic [7:0] d, input logic msb, input logic stop, input int r);
    @(negedge clk);
    rx_drv = 1'b0;
    repeat (r) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      rx_drv = msb ? d[7-i] : d[i];
      repeat (r) @(negedge clk);
    end
    rx_drv = stop;
    repeat (r) @(negedge clk);
    rx_drv = 1'b1;
    repeat (2*r) @(negedge clk);
  endtask

  task automatic take();
    rx_take = 1'b1;
    @(negedge clk);
    rx_take = 1'b0;
  endtask

  task automatic t_rx(input logic [7:0] d, input logic line_msb, input logic rmsb, input logic [1:0] sel);
    int v0 = n_val;
    logic [7:0] exp = (line_msb == rmsb) ? d : rev8(d);
    rx_msb_first = rmsb; ratio_sel = sel;
    send_line(d, line_msb, 1'b1, ratio_of(sel));
    chk(n_val == v0 + 1, "R5 rx valid count", n_val, v0 + 1);
    chk(rx_data === exp, "R4 rx data order", 32'(rx_data), 32'(exp));
    take();
  endtask

  task automatic t_glitch();
    int v0 = n_val, f0 = n_fe;
    ratio_sel = 2'b10;
    @(negedge clk);
    rx_drv = 1'b0;
    @(negedge clk);
    rx_drv = 1'b1;
    repeat (200) @(negedge clk);
    chk(n_val == v0 && n_fe == f0, "R7 glitch gives no strobe", n_val + n_fe, v0 + f0);
  endtask

  task automatic t_frame();
    int v0 = n_val, f0 = n_fe;
    logic [7:0] keep = rx_data;
    rx_msb_first = 1'b0; ratio_sel = 2'b11;
    send_line(8'h3C, 1'b0, 1'b0, 16);
    chk(n_fe == f0 + 1, "R8 frame error count", n_fe, f0 + 1);
    chk(n_val == v0, "R8 no valid on bad stop", n_val, v0);
    chk(rx_data === keep, "R8 data kept", 32'(rx_data), 32'(keep));
    t_rx(8'h5A, 1'b0, 1'b0, 2'b11);
  endtask

  task automatic t_overrun();
    int v0, o0;
    rx_msb_first = 1'b0; ratio_sel = 2'b01;
    send_line(8'h11, 1'b0, 1'b1, 8);
    v0 = n_val; o0 = n_ov;
    send_line(8'h22, 1'b0, 1'b1, 8);
    chk(n_ov == o0 + 1, "R9 overrun count", n_ov, o0 + 1);
    chk(n_val == v0, "R9 no valid on overrun", n_val, v0);
    chk(rx_data === 8'h11, "R9 data kept", 32'(rx_data), 32'h11);
    take();
    t_rx(8'h33, 1'b0, 1'b0, 2'b01);
  endtask

  task automatic t_tick();
    int busy_n = 0, v0 = n_val;
    tick_slow = 1'b1; loop = 1'b1;
    tx_msb_first = 1'b1; rx_msb_first = 1'b1; ratio_sel = 2'b01;
    @(negedge clk);
    tx_data = 8'hA5; tx_start = 1'b1;
    @(negedge clk);
    tx_start = 1'b0;
    while (tx_busy === 1'b1 && busy_n < 400) begin
      busy_n++;
      @(negedge clk);
    end
    chk(busy_n >= 159 && busy_n <= 160, "R11 busy spans 80 ticks", busy_n, 160);
    repeat (40) @(negedge clk);
    chk(n_val == v0 + 1, "R11 loopback valid", n_val, v0 + 1);
    chk(rx_data === 8'hA5, "R11 loopback data", 32'(rx_data), 32'hA5);
    take();
    tick_slow = 1'b0; loop = 1'b0;
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_tx(8'h4B, 1'b0, 2'b00, 1'b0, 1'b0);
    t_tx(8'h4B, 1'b1, 2'b01, 1'b0, 1'b0);
    t_tx(8'hC1, 1'b0, 2'b10, 1'b0, 1'b0);
    t_tx(8'h96, 1'b1, 2'b11, 1'b0, 1'b0);
    t_tx(8'h2D, 1'b0, 2'b00, 1'b1, 1'b0);
    t_tx(8'h01, 1'b0, 2'b00, 1'b0, 1'b1);
    t_rx(8'h4B, 1'b0, 1'b0, 2'b00);
    t_rx(8'h4B, 1'b1, 1'b1, 2'b01);
    t_rx(8'hC1, 1'b0, 1'b1, 2'b10);
    t_rx(8'h96, 1'b1, 1'b0, 2'b11);
    t_glitch();
    t_frame();
    t_overrun();
    t_tick();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule